// File: doc/BRIEF.md
# ADC Sample to Decimal Tenth-Millivolt Converter

This block takes a 12-bit unsigned conversion result from an analog-to-digital converter that uses a 3.3 V reference. It turns that result into five decimal digits that a seven-segment display can show. The sample is first scaled by 129/16. The scaled value is roughly ten thousand times the input voltage, so each count is about 0.1 mV, and it spans 0 to about 33016.

The binary-to-decimal step does not use a shift-and-add-3 network. A five-digit BCD counter starts at zero and steps upward. A binary shadow counter steps alongside it, and counting stops when the shadow count equals the scaled target. Each conversion therefore takes a number of cycles that grows with the sample value. A host offers a sample with a one-cycle valid strobe while busy is low. It then waits for the done pulse, and the new digits appear on the outputs in that same cycle.

Top module: `adc_mv_decimal`

## Requirements
- R1: After reset, busy_o and done_o are low and all twenty bits of digits_o are zero.
- R2: The conversion target is T = floor(sample × 129 / 16), that is (sample × 129) shifted right by four bits.
- R3: When a conversion finishes, digits_o holds T in BCD. Digit k (k = 0 for the units, up to 4 for the ten-thousands) sits at bits [4k+3:4k], and every digit is in 0..9.
- R4: The done pulse is visible exactly T+1 clock cycles after the edge that accepts the sample.
- R5: A sample is accepted when sample_valid_i is high and busy_o is low. busy_o is high from the cycle after acceptance until the last counting cycle, and it is low in the cycle where done_o is high.
- R6: A sample offered while busy_o is high is ignored. The running conversion finishes with the result of the sample that was accepted.
- R7: digits_o keeps the previous result for the whole conversion and changes only in the cycle where done_o is high.
- R8: done_o is high for exactly one cycle per accepted sample.
- R9: A zero sample still finishes, one cycle after acceptance, with a done pulse and all digits zero.
- R10: A digit that rolls over from 9 to 0 carries into the next digit in the same cycle, so a count through 9999 to 10000 produces correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_i | input | 12 | ADC conversion result |
| sample_valid_i | input | 1 | Strobe offering sample_i |
| busy_o | output | 1 | A conversion is in progress |
| digits_o | output | 20 | Five BCD digits of the last result, units at bits [3:0] |
| done_o | output | 1 | One-cycle pulse when a new result appears |

## Verification
The hardest case to reach is a strobe that arrives in the middle of a long count. To hit it, the bench pokes a second sample partway through converting a large value. It then checks that the count and the final digits still belong to the first sample. A full sweep of all 4096 samples would take far too many cycles, because each conversion lasts as many cycles as its target value. Instead, the bench uses a chosen set of samples: the zero case, values near the powers of two, one that crosses 999 to 1000, one that crosses 9999 to 10000, and the full-scale sample. It compares every result and every cycle count against arithmetic worked out in the bench.

// File: rtl/adcdec_pkg.sv
package adcdec_pkg;
  localparam int SAMPLE_W    = 12;
  localparam int SCALE_MUL   = 129;
  localparam int SCALE_SHIFT = 4;
  localparam int NUM_DIGITS  = 5;
  localparam int TARGET_W    = 16;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_COUNT = 1'b1
  } conv_state_e;
endpackage

// File: rtl/adcdec_rst_sync.sv
module adcdec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/adcdec_scale.sv
module adcdec_scale #(
  parameter int SAMPLE_W    = adcdec_pkg::SAMPLE_W,
  parameter int SCALE_MUL   = adcdec_pkg::SCALE_MUL,
  parameter int SCALE_SHIFT = adcdec_pkg::SCALE_SHIFT,
  parameter int TARGET_W    = adcdec_pkg::TARGET_W
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [TARGET_W-1:0] target_o
);
  localparam int PROD_W = SAMPLE_W + $clog2(SCALE_MUL + 1);

  logic [PROD_W-1:0] product;
  logic [PROD_W-1:0] shifted;

  always_comb begin
    product  = {{(PROD_W-SAMPLE_W){1'b0}}, sample_i} * PROD_W'(SCALE_MUL);
    shifted  = product >> SCALE_SHIFT;
    target_o = shifted[TARGET_W-1:0];
  end
endmodule

// File: rtl/adcdec_bcd_counter.sv
module adcdec_bcd_counter #(
  parameter int NUM_DIGITS = adcdec_pkg::NUM_DIGITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    inc_i,
  output logic [4*NUM_DIGITS-1:0] count_o
);
  logic [NUM_DIGITS:0] carry;

  assign carry[0] = inc_i;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    logic [3:0] dig_q;
    logic [3:0] dig_d;
    logic       at_nine;

    assign at_nine      = (dig_q == 4'd9);
    assign carry[k+1]   = carry[k] & at_nine;

    always_comb begin
      dig_d = dig_q;
      if (clr_i)         dig_d = 4'd0;
      else if (carry[k]) dig_d = at_nine ? 4'd0 : dig_q + 4'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dig_q <= 4'd0;
      else        dig_q <= dig_d;
    end

    assign count_o[4*k +: 4] = dig_q;

    // R3
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dig_q <= 4'd9);

    // R10
    rollover_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && carry[k] && at_nine) |=> (dig_q == 4'd0));
  end
endmodule

// File: rtl/adcdec_ctrl.sv
module adcdec_ctrl
  import adcdec_pkg::*;
#(
  parameter int TARGET_W = adcdec_pkg::TARGET_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [TARGET_W-1:0] scaled_i,
  output logic                clr_o,
  output logic                inc_o,
  output logic                finish_o,
  output logic                busy_o
);
  conv_state_e         state_q, state_d;
  logic [TARGET_W-1:0] target_q, target_d;
  logic [TARGET_W-1:0] shadow_q, shadow_d;
  logic                accept;
  logic                match;

  assign accept = start_i && (state_q == ST_IDLE);
  assign match  = (shadow_q == target_q);

  always_comb begin
    state_d  = state_q;
    target_d = target_q;
    shadow_d = shadow_q;
    clr_o    = 1'b0;
    inc_o    = 1'b0;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d  = ST_COUNT;
          target_d = scaled_i;
          shadow_d = '0;
          clr_o    = 1'b1;
        end
      end
      ST_COUNT: begin
        if (match) begin
          state_d  = ST_IDLE;
          finish_o = 1'b1;
        end else begin
          shadow_d = shadow_q + 1'b1;
          inc_o    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
      shadow_q <= '0;
    end else begin
      state_q  <= state_d;
      target_q <= target_d;
      shadow_q <= shadow_d;
    end
  end

  assign busy_o = (state_q == ST_COUNT);

  // R4
  shadow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (shadow_q <= target_q));

  // R6
  target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(target_q));
endmodule

// File: rtl/adc_mv_decimal.sv
module adc_mv_decimal
  import adcdec_pkg::*;
#(
  parameter int P_SAMPLE_W    = adcdec_pkg::SAMPLE_W,
  parameter int P_SCALE_MUL   = adcdec_pkg::SCALE_MUL,
  parameter int P_SCALE_SHIFT = adcdec_pkg::SCALE_SHIFT,
  parameter int P_NUM_DIGITS  = adcdec_pkg::NUM_DIGITS,
  parameter int P_TARGET_W    = adcdec_pkg::TARGET_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [P_SAMPLE_W-1:0]     sample_i,
  input  logic                      sample_valid_i,
  output logic                      busy_o,
  output logic [4*P_NUM_DIGITS-1:0] digits_o,
  output logic                      done_o
);
  localparam int DIG_BITS = 4 * P_NUM_DIGITS;

  logic                  rst_n_s;
  logic [P_TARGET_W-1:0] scaled;
  logic                  cnt_clr, cnt_inc, finish;
  logic [DIG_BITS-1:0]   live_count;
  logic [DIG_BITS-1:0]   result_q, result_d;
  logic                  done_q;

  adcdec_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  adcdec_scale #(
    .SAMPLE_W    (P_SAMPLE_W),
    .SCALE_MUL   (P_SCALE_MUL),
    .SCALE_SHIFT (P_SCALE_SHIFT),
    .TARGET_W    (P_TARGET_W)
  ) u_scale (
    .sample_i (sample_i),
    .target_o (scaled)
  );

  adcdec_ctrl #(
    .TARGET_W (P_TARGET_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_i  (sample_valid_i),
    .scaled_i (scaled),
    .clr_o    (cnt_clr),
    .inc_o    (cnt_inc),
    .finish_o (finish),
    .busy_o   (busy_o)
  );

  adcdec_bcd_counter #(
    .NUM_DIGITS (P_NUM_DIGITS)
  ) u_bcd (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .count_o (live_count)
  );

  always_comb begin
    result_d = result_q;
    if (finish) result_d = live_count;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      result_q <= result_d;
      done_q   <= finish;
    end
  end

  assign digits_o = result_q;
  assign done_o   = done_q;

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_q |=> !done_q);

  // R7
  digits_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (result_q != $past(result_q)) |-> done_q);

  // R5
  busy_low_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_q |-> !busy_o);
endmodule

// File: tb/adc_mv_decimal_tb.sv
module adc_mv_decimal_tb;
  logic        clk;
  logic        rst_n;
  logic [11:0] sample_i;
  logic        sample_valid_i;
  logic        busy_o;
  logic [19:0] digits_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  adc_mv_decimal u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_i       (sample_i),
    .sample_valid_i (sample_valid_i),
    .busy_o         (busy_o),
    .digits_o       (digits_o),
    .done_o         (done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [19:0] to_bcd(int v);
    logic [19:0] r;
    int t;
    t = v;
    for (int k = 0; k < 5; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Converts one sample; optionally pokes a second sample mid-count.
  task automatic convert(int s, bit poke);
    int target, n;
    logic [19:0] prev;
    bit held, busy_ok;
    target = (s * 129) >> 4;
    prev = digits_o;
    @(negedge clk);
    sample_i = 12'(s);
    sample_valid_i = 1'b1;
    @(negedge clk);
    sample_valid_i = 1'b0;
    sample_i = 12'h000;
    check(busy_o === 1'b1 || target == 0 && done_o === 1'b0 && busy_o === 1'b1,
          "R5", "busy after accept", int'(busy_o), 1);
    n = 0;
    held = 1;
    busy_ok = 1;
    while (done_o !== 1'b1 && n < 40000) begin
      if (digits_o !== prev) held = 0;
      if (busy_o !== 1'b1) busy_ok = 0;
      if (poke && n == target / 2) begin
        sample_i = 12'd5;
        sample_valid_i = 1'b1;
      end else begin
        sample_valid_i = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    sample_valid_i = 1'b0;
    check(held, "R7", "digits held during count", 0, 0);
    check(busy_ok, "R5", "busy held during count", 0, 0);
    check(n == target + 1, "R4", "cycles to done", n, target + 1);
    check(digits_o === to_bcd(target), poke ? "R6" : "R3", "digits",
          int'(digits_o), int'(to_bcd(target)));
    check(busy_o === 1'b0, "R5", "busy low at done", int'(busy_o), 0);
    @(negedge clk);
    check(done_o === 1'b0, "R8", "done one cycle", int'(done_o), 0);
    check(digits_o === to_bcd(target), "R7", "digits kept after done",
          int'(digits_o), int'(to_bcd(target)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    sample_i = '0;
    sample_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy_o === 1'b0, "R1", "busy after reset", int'(busy_o), 0);
    check(done_o === 1'b0, "R1", "done after reset", int'(done_o), 0);
    check(digits_o === 20'h0, "R1", "digits after reset", int'(digits_o), 0);

    // R9 zero sample
    convert(0, 0);
    // R2 scaling across small values and powers of two
    convert(1, 0);
    convert(2, 0);
    convert(15, 0);
    convert(16, 0);
    convert(17, 0);
    convert(124, 0);
    convert(125, 0);
    // R10 crosses 999 -> 1000 and 9999 -> 10000
    convert(1240, 0);
    convert(2048, 0);
    // R6 strobe while busy is ignored
    convert(3000, 1);
    // full scale
    convert(4095, 0);
    convert(0, 0);
    finish_run();
  end
endmodule